// File: doc/BRIEF.md
# Microcode Sequencer with Microbranches

This block is the control half of a microcoded processor whose datapath shares a single bus. A state register addresses a control store, and the selected microinstruction drives every datapath control line. These lines are the register load strobes, the bus driver enables, the ALU operation, the immediate format, the register file port select and the gated register-file and memory access strobes. Each microinstruction also carries a 3-bit branch kind and a target state. Together with the ALU zero flag, the memory busy flag and the opcode and function fields of the instruction register, these two fields decide which state comes next.

The control store is read synchronously, so its registered output always belongs to the current state. It holds a fixed microprogram of 25 states:

- State 0 starts fetch; state 1 spins on memory; state 2 dispatches.
- Register-register add uses states 3-5 and the word load uses states 6-10.
- Branch-if-equal uses states 11-14 and branch-if-not-equal uses states 18-21. Both share a taken path at states 15-17.
- Jump-and-link uses states 22-24.
- All other entries jump to the illegal state 31, which jumps to itself.

Top module: `ucs_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is 0 (fetch). The outputs then show state 0's word: register read of the PC (`rf_re_o`=1), register driver on the bus, MA and A loads.
- R2: A "next" microinstruction (branch kind 0) moves to the current state plus one. Examples are states 0, 3, 4, 6, 7, 8, 11, 12, 15, 16, 18, 19, 22 and 23.
- R3: A "jump" microinstruction (kind 1) moves to its target field whatever the flags are. States 5, 10, 14, 17, 21 and 24 jump to 0.
- R4: A "branch if zero" microinstruction (kind 2, state 13 with target 15) goes to the target when `alu_zero_i`=1 and to state 14 otherwise.
- R5: A "branch if not zero" microinstruction (kind 3, state 20 with target 15) goes to the target when `alu_zero_i`=0 and to state 21 otherwise.
- R6: A "dispatch" microinstruction (kind 4, state 2) maps the opcode and function fields to an entry state:
  - opcode 0x33 with function 0 goes to 3;
  - opcode 0x03 with function 2 goes to 6;
  - opcode 0x63 with function 0 goes to 11;
  - opcode 0x63 with function 1 goes to 18;
  - opcode 0x6F with any function goes to 22.
- R7: Any other opcode and function pair dispatches to the illegal state 31. Unprogrammed entries and unknown branch kinds also lead there. State 31 holds until reset.
- R8: A "spin" microinstruction (kind 5, states 1 and 9) holds the state while `mem_busy_i`=1 and advances by one in the first cycle it is 0.
- R9: Register and memory strobes follow the enable bit. The write strobe equals enable AND write bit, and the read strobe equals enable AND NOT write bit. With enable 0, no strobe rises even when the write bit is 1 (states 10, 13 and 20 carry such bits).
- R10: At most one of the four bus driver enables is 1 in any cycle, and each state drives the bus with the source its operation needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| mem_busy_i | input | 1 | Memory not ready |
| ir_opc_i | input | 7 | Opcode field of the instruction register |
| ir_fn_i | input | 3 | Function field of the instruction register |
| state_o | output | 5 | Current microprogram state |
| ir_ld_o | output | 1 | Load instruction register from bus |
| a_ld_o | output | 1 | Load ALU operand A from bus |
| b_ld_o | output | 1 | Load ALU operand B from bus |
| ma_ld_o | output | 1 | Load memory address register from bus |
| reg_sel_o | output | 2 | Register port select: 0 rs1, 1 rs2, 2 rd, 3 PC |
| rf_we_o | output | 1 | Register file write strobe |
| rf_re_o | output | 1 | Register file read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| alu_op_o | output | 4 | ALU operation code |
| imm_sel_o | output | 3 | Immediate format select |
| drv_alu_o | output | 1 | ALU drives the bus |
| drv_reg_o | output | 1 | Register file drives the bus |
| drv_mem_o | output | 1 | Memory drives the bus |
| drv_imm_o | output | 1 | Immediate generator drives the bus |

## Verification
The bench uses the package sizes: a 5-bit state (32 control words), a 7-bit opcode and a 3-bit function field. With these sizes, every programmed state, the dispatch from fetch into all five handlers, the illegal trap and its release by reset are reachable in a few thousand cycles. Both directions of each zero-flag branch and spin stalls of random length are exercised with random flags. The unprogrammed words 25 to 30 cannot be reached through dispatch, so they are only covered through the package function that fills them.

// File: rtl/ucs_pkg.sv
`timescale 1ns/1ps
package ucs_pkg;
  localparam int ST_W   = 5;
  localparam int DEPTH  = 1 << ST_W;
  localparam int OPC_W  = 7;
  localparam int FN_W   = 3;
  localparam int DRV_N  = 4;
  localparam int D_ALU  = 3;
  localparam int D_REG  = 2;
  localparam int D_MEM  = 1;
  localparam int D_IMM  = 0;

  localparam logic [ST_W-1:0] ST_FETCH = '0;
  localparam logic [ST_W-1:0] ST_ILL   = '1;

  typedef enum logic [2:0] {
    BR_NEXT = 3'd0, BR_JUMP = 3'd1, BR_EZ = 3'd2,
    BR_NZ   = 3'd3, BR_DISP = 3'd4, BR_SPIN = 3'd5
  } br_e;

  typedef enum logic [3:0] {
    ALU_CPA = 4'd0, ALU_CPB = 4'd1, ALU_INC4 = 4'd2, ALU_ADD = 4'd3, ALU_SUB = 4'd4
  } alu_e;

  typedef enum logic [1:0] {RS_RS1 = 2'd0, RS_RS2 = 2'd1, RS_RD = 2'd2, RS_PC = 2'd3} rsel_e;
  typedef enum logic [2:0] {IMM_I = 3'd0, IMM_U = 3'd1, IMM_S = 3'd2, IMM_J = 3'd3, IMM_B = 3'd4} imm_e;

  typedef struct packed {
    br_e              br;
    logic [ST_W-1:0]  tgt;
    logic             ir_ld;
    logic             a_ld;
    logic             b_ld;
    logic             ma_ld;
    rsel_e            rsel;
    logic             reg_wr;
    logic             reg_en;
    logic             mem_wr;
    logic             mem_en;
    alu_e             alu;
    imm_e             imm;
    logic [DRV_N-1:0] drv;
  } uinst_t;

  // Microprogram contents, one word per state.
  function automatic uinst_t uc_word(input int unsigned a);
    uinst_t u;
    u = '0;
    u.br  = BR_JUMP;
    u.tgt = ST_ILL;
    case (a)
      0:  begin u.br = BR_NEXT; u.rsel = RS_PC; u.reg_en = 1'b1; u.drv[D_REG] = 1'b1;
                u.ma_ld = 1'b1; u.a_ld = 1'b1; end
      1:  begin u.br = BR_SPIN; u.ir_ld = 1'b1; u.mem_en = 1'b1; u.drv[D_MEM] = 1'b1; end
      2:  begin u.br = BR_DISP; u.alu = ALU_INC4; u.drv[D_ALU] = 1'b1; u.rsel = RS_PC;
                u.reg_en = 1'b1; u.reg_wr = 1'b1; end
      3, 6, 11, 18:
          begin u.br = BR_NEXT; u.rsel = RS_RS1; u.reg_en = 1'b1; u.drv[D_REG] = 1'b1;
                u.a_ld = 1'b1; end
      4, 12, 19:
          begin u.br = BR_NEXT; u.rsel = RS_RS2; u.reg_en = 1'b1; u.drv[D_REG] = 1'b1;
                u.b_ld = 1'b1; end
      5:  begin u.tgt = ST_FETCH; u.alu = ALU_ADD; u.drv[D_ALU] = 1'b1; u.rsel = RS_RD;
                u.reg_en = 1'b1; u.reg_wr = 1'b1; end
      7:  begin u.br = BR_NEXT; u.imm = IMM_I; u.drv[D_IMM] = 1'b1; u.b_ld = 1'b1; end
      8:  begin u.br = BR_NEXT; u.alu = ALU_ADD; u.drv[D_ALU] = 1'b1; u.ma_ld = 1'b1; end
      9:  begin u.br = BR_SPIN; u.mem_en = 1'b1; u.drv[D_MEM] = 1'b1; u.rsel = RS_RD;
                u.reg_en = 1'b1; u.reg_wr = 1'b1; end
      10: begin u.tgt = ST_FETCH; u.mem_wr = 1'b1; end
      13: begin u.br = BR_EZ; u.tgt = ST_W'(15); u.alu = ALU_SUB; u.reg_wr = 1'b1; end
      14, 21: u.tgt = ST_FETCH;
      15, 22:
          begin u.br = BR_NEXT; u.rsel = RS_PC; u.reg_en = 1'b1; u.drv[D_REG] = 1'b1;
                u.a_ld = 1'b1; end
      16: begin u.br = BR_NEXT; u.imm = IMM_B; u.drv[D_IMM] = 1'b1; u.b_ld = 1'b1; end
      17, 24:
          begin u.tgt = ST_FETCH; u.alu = ALU_ADD; u.drv[D_ALU] = 1'b1; u.rsel = RS_PC;
                u.reg_en = 1'b1; u.reg_wr = 1'b1; end
      20: begin u.br = BR_NZ; u.tgt = ST_W'(15); u.alu = ALU_SUB; u.reg_wr = 1'b1; end
      23: begin u.br = BR_NEXT; u.imm = IMM_J; u.drv[D_IMM] = 1'b1; u.b_ld = 1'b1; end
      default: ;
    endcase
    return u;
  endfunction

  // Entry state for each decoded instruction class.
  function automatic logic [ST_W-1:0] disp_entry(input logic [OPC_W-1:0] opc,
                                                input logic [FN_W-1:0] fn);
    logic [ST_W-1:0] s;
    s = ST_ILL;
    case (opc)
      7'h33: if (fn == 3'd0) s = ST_W'(3);
      7'h03: if (fn == 3'd2) s = ST_W'(6);
      7'h63: if (fn == 3'd0) s = ST_W'(11);
             else if (fn == 3'd1) s = ST_W'(18);
      7'h6F: s = ST_W'(22);
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ucs_rom.sv
`timescale 1ns/1ps
module ucs_rom
  import ucs_pkg::*;
#(
  parameter int N_WORDS = DEPTH,
  localparam int AW = $clog2(N_WORDS)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output uinst_t        data_q
);
  uinst_t rom_mem [N_WORDS];

  for (genvar a = 0; a < N_WORDS; a++) begin : g_word
    assign rom_mem[a] = uc_word(a);
  end

  always_ff @(posedge clk) begin
    data_q <= rom_mem[addr];
  end
endmodule

// File: rtl/ucs_next.sv
`timescale 1ns/1ps
module ucs_next
  import ucs_pkg::*;
(
  input  logic [ST_W-1:0]  cur,
  input  br_e              br,
  input  logic [ST_W-1:0]  tgt,
  input  logic             zero,
  input  logic             busy,
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  output logic [ST_W-1:0]  nxt
);
  logic [ST_W-1:0] inc;
  assign inc = ST_W'(cur + 1'b1);

  always_comb begin
    case (br)
      BR_NEXT: nxt = inc;
      BR_JUMP: nxt = tgt;
      BR_EZ:   nxt = zero ? tgt : inc;
      BR_NZ:   nxt = zero ? inc : tgt;
      BR_DISP: nxt = disp_entry(opc, fn);
      BR_SPIN: nxt = busy ? cur : inc;
      default: nxt = ST_ILL;
    endcase
  end
endmodule

// File: rtl/ucs_decode.sv
`timescale 1ns/1ps
module ucs_decode
  import ucs_pkg::*;
(
  input  uinst_t     u,
  output logic       ir_ld,
  output logic       a_ld,
  output logic       b_ld,
  output logic       ma_ld,
  output logic [1:0] reg_sel,
  output logic       rf_we,
  output logic       rf_re,
  output logic       mem_we,
  output logic       mem_re,
  output logic [3:0] alu_op,
  output logic [2:0] imm_sel,
  output logic [DRV_N-1:0] drv
);
  logic unused_seq_bits;
  assign unused_seq_bits = ^{u.br, u.tgt};

  assign ir_ld   = u.ir_ld;
  assign a_ld    = u.a_ld;
  assign b_ld    = u.b_ld;
  assign ma_ld   = u.ma_ld;
  assign reg_sel = u.rsel;
  assign rf_we   = u.reg_en &  u.reg_wr;
  assign rf_re   = u.reg_en & ~u.reg_wr;
  assign mem_we  = u.mem_en &  u.mem_wr;
  assign mem_re  = u.mem_en & ~u.mem_wr;
  assign alu_op  = u.alu;
  assign imm_sel = u.imm;
  assign drv     = u.drv;
endmodule

// File: rtl/ucs_sequencer.sv
`timescale 1ns/1ps
module ucs_sequencer
  import ucs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             alu_zero_i,
  input  logic             mem_busy_i,
  input  logic [OPC_W-1:0] ir_opc_i,
  input  logic [FN_W-1:0]  ir_fn_i,
  output logic [ST_W-1:0]  state_o,
  output logic             ir_ld_o,
  output logic             a_ld_o,
  output logic             b_ld_o,
  output logic             ma_ld_o,
  output logic [1:0]       reg_sel_o,
  output logic             rf_we_o,
  output logic             rf_re_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [3:0]       alu_op_o,
  output logic [2:0]       imm_sel_o,
  output logic             drv_alu_o,
  output logic             drv_reg_o,
  output logic             drv_mem_o,
  output logic             drv_imm_o
);
  logic [ST_W-1:0]  cur_q;
  logic [ST_W-1:0]  nxt;
  logic [ST_W-1:0]  rd_addr;
  uinst_t           uop_q;
  logic [DRV_N-1:0] drv;

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_FETCH;
    else     cur_q <= nxt;
  end

  // The store is addressed with the state being loaded, so its
  // registered word always matches cur_q.
  assign rd_addr = rst ? ST_FETCH : nxt;

  ucs_rom #(.N_WORDS(DEPTH)) u_rom (
    .clk    (clk),
    .addr   (rd_addr),
    .data_q (uop_q)
  );

  ucs_next u_next (
    .cur  (cur_q),
    .br   (uop_q.br),
    .tgt  (uop_q.tgt),
    .zero (alu_zero_i),
    .busy (mem_busy_i),
    .opc  (ir_opc_i),
    .fn   (ir_fn_i),
    .nxt  (nxt)
  );

  ucs_decode u_dec (
    .u       (uop_q),
    .ir_ld   (ir_ld_o),
    .a_ld    (a_ld_o),
    .b_ld    (b_ld_o),
    .ma_ld   (ma_ld_o),
    .reg_sel (reg_sel_o),
    .rf_we   (rf_we_o),
    .rf_re   (rf_re_o),
    .mem_we  (mem_we_o),
    .mem_re  (mem_re_o),
    .alu_op  (alu_op_o),
    .imm_sel (imm_sel_o),
    .drv     (drv)
  );

  assign state_o   = cur_q;
  assign drv_alu_o = drv[D_ALU];
  assign drv_reg_o = drv[D_REG];
  assign drv_mem_o = drv[D_MEM];
  assign drv_imm_o = drv[D_IMM];
endmodule

// File: rtl/ucs_sequencer_chk.sv
`timescale 1ns/1ps
module ucs_sequencer_chk
  import ucs_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [ST_W-1:0] state,
  input logic [2:0]      br,
  input logic [ST_W-1:0] tgt,
  input logic            zero,
  input logic            busy,
  input logic            reg_en,
  input logic            mem_en,
  input logic            rf_we,
  input logic            rf_re,
  input logic            mem_we,
  input logic            mem_re,
  input logic [3:0]      drv
);
  AST_RESET_FETCH: assert property (@(posedge clk) rst |=> state == ST_FETCH); // R1
  AST_NEXT_INC: assert property (@(posedge clk) disable iff (rst)
    br == 3'd0 |=> state == ST_W'($past(state) + 1'b1)); // R2
  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
    br == 3'd1 |=> state == $past(tgt)); // R3
  AST_EZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br == 3'd2 && zero) |=> state == $past(tgt)); // R4
  AST_NZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br == 3'd3 && !zero) |=> state == $past(tgt)); // R5
  AST_ILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    state == ST_ILL |=> state == ST_ILL); // R7
  AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (br == 3'd5 && busy) |=> $stable(state)); // R8
  AST_SPIN_GO: assert property (@(posedge clk) disable iff (rst)
    (br == 3'd5 && !busy) |=> state == ST_W'($past(state) + 1'b1)); // R8
  AST_RF_GATED: assert property (@(posedge clk) disable iff (rst)
    !reg_en |-> !(rf_we || rf_re)); // R9
  AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
    !mem_en |-> !(mem_we || mem_re)); // R9
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv)); // R10
endmodule

bind ucs_sequencer ucs_sequencer_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .state  (state_o),
  .br     (uop_q.br),
  .tgt    (uop_q.tgt),
  .zero   (alu_zero_i),
  .busy   (mem_busy_i),
  .reg_en (uop_q.reg_en),
  .mem_en (uop_q.mem_en),
  .rf_we  (rf_we_o),
  .rf_re  (rf_re_o),
  .mem_we (mem_we_o),
  .mem_re (mem_re_o),
  .drv    ({drv_alu_o, drv_reg_o, drv_mem_o, drv_imm_o})
);

// File: tb/ucs_sequencer_bench.sv
`timescale 1ns/1ps
module ucs_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       zero = 1'b0;
  logic       busy = 1'b0;
  logic [6:0] opc = '0;
  logic [2:0] fn = '0;
  logic [4:0] state;
  logic ir_ld, a_ld, b_ld, ma_ld, rf_we, rf_re, mem_we, mem_re;
  logic d_alu, d_reg, d_mem, d_imm;
  logic [1:0] reg_sel;
  logic [3:0] alu_op;
  logic [2:0] imm_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ucs_sequencer u_ucs_sequencer (
    .clk(clk), .rst(rst), .alu_zero_i(zero), .mem_busy_i(busy),
    .ir_opc_i(opc), .ir_fn_i(fn), .state_o(state),
    .ir_ld_o(ir_ld), .a_ld_o(a_ld), .b_ld_o(b_ld), .ma_ld_o(ma_ld),
    .reg_sel_o(reg_sel), .rf_we_o(rf_we), .rf_re_o(rf_re),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .alu_op_o(alu_op), .imm_sel_o(imm_sel),
    .drv_alu_o(d_alu), .drv_reg_o(d_reg), .drv_mem_o(d_mem), .drv_imm_o(d_imm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected entry state after dispatch (R6, R7).
  function automatic logic [4:0] exp_disp(input logic [6:0] o, input logic [2:0] f);
    if (o == 7'h33 && f == 3'd0) return 5'd3;
    if (o == 7'h03 && f == 3'd2) return 5'd6;
    if (o == 7'h63 && f == 3'd0) return 5'd11;
    if (o == 7'h63 && f == 3'd1) return 5'd18;
    if (o == 7'h6F)              return 5'd22;
    return 5'd31;
  endfunction

  function automatic logic [4:0] exp_next(input logic [4:0] s, input logic z, input logic b,
                                          input logic [6:0] o, input logic [2:0] f,
                                          output string tag);
    case (s)
      5'd1, 5'd9: begin tag = "R8"; return b ? s : s + 5'd1; end
      5'd2: begin
        tag = (exp_disp(o, f) == 5'd31) ? "R7" : "R6";
        return exp_disp(o, f);
      end
      5'd5, 5'd10, 5'd14, 5'd17, 5'd21, 5'd24: begin tag = "R3"; return 5'd0; end
      5'd13: begin tag = "R4"; return z ? 5'd15 : 5'd14; end
      5'd20: begin tag = "R5"; return z ? 5'd21 : 5'd15; end
      5'd31: begin tag = "R7"; return 5'd31; end
      5'd0, 5'd3, 5'd4, 5'd6, 5'd7, 5'd8, 5'd11, 5'd12, 5'd15, 5'd16,
      5'd18, 5'd19, 5'd22, 5'd23: begin tag = "R2"; return s + 5'd1; end
      default: begin tag = "R7"; return 5'd31; end
    endcase
  endfunction

  // {rf_we, rf_re, mem_we, mem_re, alu, reg, mem, imm}
  function automatic logic [7:0] exp_ctrl(input logic [4:0] s);
    case (s)
      5'd0, 5'd3, 5'd4, 5'd6, 5'd11, 5'd12, 5'd15, 5'd18, 5'd19, 5'd22: return 8'b0100_0100;
      5'd1:                 return 8'b0001_0010;
      5'd2, 5'd5, 5'd17, 5'd24: return 8'b1000_1000;
      5'd7, 5'd16, 5'd23:   return 8'b0000_0001;
      5'd8:                 return 8'b0000_1000;
      5'd9:                 return 8'b1001_0010;
      default:              return 8'b0000_0000;
    endcase
  endfunction

  task automatic check_ctrl(input logic [4:0] s);
    logic [3:0] strb;
    logic [3:0] drvs;
    logic [7:0] e;
    e = exp_ctrl(s);
    strb = {rf_we, rf_re, mem_we, mem_re};
    drvs = {d_alu, d_reg, d_mem, d_imm};
    chk(strb == e[7:4], "R9 strobes", strb, e[7:4]);
    chk(drvs == e[3:0] && $countones(drvs) <= 1, "R10 bus drivers", drvs, e[3:0]);
  endtask

  task automatic pick_ir();
    int unsigned r;
    r = $urandom % 8;
    fn = 3'($urandom);
    case (r)
      0: begin opc = 7'h33; fn = 3'd0; end
      1, 7: begin opc = 7'h03; fn = 3'd2; end
      2: begin opc = 7'h63; fn = 3'd0; end
      3: begin opc = 7'h63; fn = 3'd1; end
      4: opc = 7'h6F;
      5: opc = 7'h33;
      default: opc = 7'($urandom);
    endcase
  endtask

  initial begin
    logic [4:0] exp_s;
    logic [4:0] nexp;
    string tag;
    int ill_cnt;
    void'($urandom(32'd20250));
    ill_cnt = 0;
    @(negedge clk);
    @(negedge clk);
    chk(state == 5'd0, "R1 reset state", state, 0);
    check_ctrl(5'd0);
    chk(a_ld && ma_ld && reg_sel == 2'd3, "R1 fetch loads", {a_ld, ma_ld, reg_sel}, 4'b1111);
    exp_s = 5'd0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (exp_s == 5'd31 && ill_cnt >= 2) begin
        rst = 1'b1;
        nexp = 5'd0;
        tag = "R1";
        ill_cnt = 0;
      end else begin
        rst = 1'b0;
        zero = 1'($urandom);
        busy = ($urandom % 3) == 0;
        pick_ir();
        if (exp_s == 5'd31) ill_cnt++;
        nexp = exp_next(exp_s, zero, busy, opc, fn, tag);
      end
      @(negedge clk);
      chk(state == nexp, tag, state, nexp);
      check_ctrl(nexp);
      exp_s = nexp;
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule